// File: doc/BRIEF.md
# Signed Add/Subtract Unit with Compare Status

This block is a two-operand arithmetic stage with a status register next to it. An operation is presented on a single enable together with a 6-bit opcode and two 32-bit operands. Addition and subtraction produce a registered result with a one-cycle valid pulse, so the caller can write it back. A compare produces no result. Instead it records the signed ordering of the two operands as three flags in the top bits of the status register.

The lower 29 bits of the status register are general-purpose storage. Compares never touch them, and a dedicated write port loads them. The interface has no back-pressure. One operation can be accepted every cycle, the result is presented for exactly the one cycle after the operation was accepted, and the consumer must take it in that cycle. The operation enable and result valid act as a valid-only stream whose ready is permanently high.

Top module: `arith_flag_unit`

## Requirements
- R1: With `op_en` high and `op_code` = 13, on the next clock edge `res_valid` is 1 and `res_data` equals `opnd_a + opnd_b` modulo 2^32.
- R2: With `op_en` high and `op_code` = 14, on the next clock edge `res_valid` is 1 and `res_data` equals `opnd_a - opnd_b` modulo 2^32.
- R3: With `op_en` high and `op_code` = 15 (compare), on the next edge `res_valid` is 0 and `res_data` keeps its previous value.
- R4: After a compare, `status[31]` is 1 exactly when `opnd_a` is greater than `opnd_b` as signed two's-complement numbers.
- R5: After a compare, `status[30]` is 1 exactly when `opnd_a` is less than `opnd_b` as signed numbers.
- R6: After a compare, `status[29]` is 1 exactly when the operands are equal.
- R7: After every compare, exactly one of `status[31:29]` is set and the other two are cleared.
- R8: Add and subtract leave all of `status` unchanged.
- R9: `status[28:0]` loads `sr_wr_data` on the edge where `sr_wr_en` is high. Otherwise these bits hold their value, including across compares. A write in the same cycle as a compare takes effect together with the compare's flag update.
- R10: If `op_en` is low, or if the opcode is anything other than 13, 14 or 15, `res_valid` is 0 on the next edge, `res_data` is held, and `status[31:29]` is unchanged.
- R11: While `rst_n` is low, `status`, `res_data` and `res_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous release |
| op_en | input | 1 | Operation present this cycle |
| op_code | input | 6 | 13 add, 14 subtract, 15 compare |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| sr_wr_en | input | 1 | Load the low status bits |
| sr_wr_data | input | 29 | Value for `status[28:0]` |
| res_data | output | 32 | Registered add/subtract result |
| res_valid | output | 1 | One-cycle pulse marking a fresh result |
| status | output | 32 | Flags in [31:29], general bits in [28:0] |

## Verification
The bench aims at the signed boundary. It compares 0x7FFFFFFF with 0x80000000, and -1 with 0. An unsigned comparator would set the opposite flag in both cases. It also drives wrap-around sums and differences such as 0xFFFFFFFF + 1 and 0 - 1, where a design that saturates or sign-extends would give a wrong value. Further cases are a compare together with a low-bit write, a compare that wrongly raises `res_valid` or overwrites `res_data`, and unsupported opcodes 0 and 16. A sloppy opcode decode would act on those opcodes. Random traffic mixes all of these cases and checks that no flag survives the next compare and that the general bits never move without a write.

// File: rtl/arith_flag_pkg.sv
package arith_flag_pkg;
  localparam int unsigned OPC_W = 6;
  localparam logic [OPC_W-1:0] OPC_ADD = 6'd13;
  localparam logic [OPC_W-1:0] OPC_SUB = 6'd14;
  localparam logic [OPC_W-1:0] OPC_CMP = 6'd15;
  localparam int unsigned NFLAGS = 3;

  typedef struct packed {
    logic gt;
    logic lt;
    logic eq;
  } cmp_flags_t;
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] y
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin;

  always_comb begin
    b_eff = b ^ {WIDTH{sub}};
    cin   = {{(WIDTH-1){1'b0}}, sub};
    y     = a + b_eff + cin;
  end
endmodule

// File: rtl/signed_compare.sv
module signed_compare
  import arith_flag_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output cmp_flags_t       flags
);
  always_comb begin
    flags.eq = (a == b);
    flags.gt = ($signed(a) > $signed(b));
    flags.lt = ($signed(a) < $signed(b));
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import arith_flag_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmp_upd,
  input  cmp_flags_t               cmp_in,
  input  logic                     wr_en,
  input  logic [WIDTH-NFLAGS-1:0]  wr_data,
  output logic [WIDTH-1:0]         sr_q
);
  localparam int unsigned LOW_W = WIDTH - NFLAGS;

  logic [NFLAGS-1:0] flag_q;
  logic [LOW_W-1:0]  low_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else if (cmp_upd) begin
      flag_q <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (wr_en) begin
      low_q <= wr_data;
    end
  end

  assign sr_q = {flag_q, low_q};

  // R7: a compare leaves exactly one flag set
  assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_upd |=> $onehot(sr_q[WIDTH-1 -: NFLAGS]));

  // R9: low bits load from the write port
  assert_low_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> sr_q[LOW_W-1:0] == $past(wr_data));

  // R9: low bits hold without a write, compares included
  assert_low_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sr_q[LOW_W-1:0]));

  // R8 / R10: flags hold without a compare
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_upd |=> $stable(sr_q[WIDTH-1 -: NFLAGS]));
endmodule

// File: rtl/arith_flag_unit.sv
module arith_flag_unit
  import arith_flag_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_en,
  input  logic [OPC_W-1:0]        op_code,
  input  logic [WIDTH-1:0]        opnd_a,
  input  logic [WIDTH-1:0]        opnd_b,
  input  logic                    sr_wr_en,
  input  logic [WIDTH-NFLAGS-1:0] sr_wr_data,
  output logic [WIDTH-1:0]        res_data,
  output logic                    res_valid,
  output logic [WIDTH-1:0]        status
);
  logic       do_add, do_sub, do_cmp, do_arith;
  logic [WIDTH-1:0] arith_y;
  cmp_flags_t cmp_now;

  always_comb begin
    do_add   = op_en && (op_code == OPC_ADD);
    do_sub   = op_en && (op_code == OPC_SUB);
    do_cmp   = op_en && (op_code == OPC_CMP);
    do_arith = do_add || do_sub;
  end

  addsub_core #(.WIDTH(WIDTH)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .sub (do_sub),
    .y   (arith_y)
  );

  signed_compare #(.WIDTH(WIDTH)) u_cmp (
    .a     (opnd_a),
    .b     (opnd_b),
    .flags (cmp_now)
  );

  status_reg #(.WIDTH(WIDTH)) u_sr (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmp_upd (do_cmp),
    .cmp_in  (cmp_now),
    .wr_en   (sr_wr_en),
    .wr_data (sr_wr_data),
    .sr_q    (status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= do_arith;
      if (do_arith) res_data <= arith_y;
    end
  end

  // R1: sum appears one edge later
  assert_add_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_ADD) |=>
      res_valid && res_data == $past(opnd_a) + $past(opnd_b));

  // R2: difference appears one edge later
  assert_sub_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_SUB) |=>
      res_valid && res_data == $past(opnd_a) - $past(opnd_b));

  // R3: compare writes back nothing
  assert_cmp_no_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_CMP) |=> !res_valid && $stable(res_data));

  // R4: greater flag follows signed ordering
  assert_gt_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_CMP) |=>
      status[WIDTH-1] == ($signed($past(opnd_a)) > $signed($past(opnd_b))));

  // R5: less flag follows signed ordering
  assert_lt_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_CMP) |=>
      status[WIDTH-2] == ($signed($past(opnd_a)) < $signed($past(opnd_b))));

  // R6: zero flag on equality
  assert_eq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_code == OPC_CMP) |=>
      status[WIDTH-3] == ($past(opnd_a) == $past(opnd_b)));

  // R10: idle or unknown opcode yields nothing
  assert_no_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_en && (op_code == OPC_ADD || op_code == OPC_SUB || op_code == OPC_CMP))
      |=> !res_valid && $stable(res_data) && $stable(status[WIDTH-1 -: NFLAGS]));
endmodule

// File: tb/test_arith_flag_unit.sv
`timescale 1ns/1ps
module test_arith_flag_unit;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_en = 1'b0;
  logic [5:0] op_code = '0;
  logic [W-1:0] opnd_a = '0, opnd_b = '0;
  logic sr_wr_en = 1'b0;
  logic [W-4:0] sr_wr_data = '0;
  logic [W-1:0] res_data;
  logic res_valid;
  logic [W-1:0] status;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [W-1:0] exp_res = '0;
  logic         exp_vld = 1'b0;
  logic [W-1:0] exp_sr  = '0;

  always #10 clk = ~clk;

  arith_flag_unit i_arith_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .res_data(res_data), .res_valid(res_valid),
    .status(status)
  );

  function automatic logic [2:0] ref_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    if ($signed(a) > $signed(b)) return 3'b100;
    if ($signed(a) < $signed(b)) return 3'b010;
    return 3'b001;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, update the model, check at the next falling edge.
  task automatic step(input logic en, input logic [5:0] opc, input logic [W-1:0] a,
                      input logic [W-1:0] b, input logic we, input logic [W-4:0] wd,
                      input string tag);
    op_en = en; op_code = opc; opnd_a = a; opnd_b = b;
    sr_wr_en = we; sr_wr_data = wd;
    exp_vld = 1'b0;
    if (en && opc == 6'd13) begin exp_res = a + b; exp_vld = 1'b1; end
    if (en && opc == 6'd14) begin exp_res = a - b; exp_vld = 1'b1; end
    if (en && opc == 6'd15) exp_sr[31:29] = ref_flags(a, b);
    if (we) exp_sr[28:0] = wd;
    @(negedge clk);
    check({tag, " valid"}, {31'd0, res_valid}, {31'd0, exp_vld});
    check({tag, " data"}, res_data, exp_res);
    check({tag, " status"}, status, exp_sr);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 status", status, '0);
    check("R11 data", res_data, '0);
    check("R11 valid", {31'd0, res_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 13, 32'hFFFF_FFFF, 32'h1, 0, '0, "R1 add wrap");
    step(1, 13, 32'h1234_0000, 32'h0000_5678, 0, '0, "R1 add");
    step(1, 14, 32'h0, 32'h1, 0, '0, "R2 sub wrap");
    step(1, 14, 32'h8000_0000, 32'h1, 0, '0, "R2 sub");
    step(1, 15, 32'h7FFF_FFFF, 32'h8000_0000, 0, '0, "R4 gt signed edge");
    step(1, 15, 32'hFFFF_FFFF, 32'h0, 0, '0, "R5 lt minus one");
    step(1, 15, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 0, '0, "R6 eq");
    step(0, 0, '0, '0, 1, 29'h1ABC_DEF0, "R9 low write");
    step(1, 15, 32'h5, 32'h3, 0, '0, "R9 hold across compare R7");
    step(1, 15, 32'h3, 32'h5, 1, 29'h0F0F_0F0F, "R9 write with compare");
    step(1, 13, 32'h10, 32'h20, 0, '0, "R8 add keeps status");
    step(1, 14, 32'h10, 32'h20, 0, '0, "R8 sub keeps status");
    step(1, 15, 32'h1, 32'h1, 0, '0, "R3 compare no writeback");
    step(1, 0, 32'h1, 32'h2, 0, '0, "R10 opcode 0");
    step(1, 16, 32'h1, 32'h2, 0, '0, "R10 opcode 16");
    step(0, 13, 32'h1, 32'h2, 0, '0, "R10 enable low");

    for (int i = 0; i < 400; i++) begin
      logic [5:0] opc;
      logic [W-1:0] a, b;
      int sel;
      sel = $urandom_range(0, 9);
      opc = (sel < 3) ? 6'd13 : (sel < 6) ? 6'd14 : (sel < 9) ? 6'd15 : 6'($urandom_range(0, 63));
      a = $urandom();
      b = ($urandom_range(0, 7) == 0) ? a : $urandom();
      step($urandom_range(0, 5) != 0, opc, a, b, $urandom_range(0, 3) == 0,
           29'($urandom()), "R7 random mix");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule